// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a narrow host port reach a wide internal register space. The host sees eight byte-wide locations, selected by one-hot decoded strobes. Two of them hold a 12-bit internal address. Four of them form a 32-bit data word. When the host touches data byte 0, the bridge starts one transfer on the internal register bus. A write to byte 0 sends the assembled word out. A read of byte 0 fetches a word and latches it into the four byte registers.

Two enable bits in the upper address location make the internal address step by one after a write, after a read, or after both. This suits sequential sweeps through a table. Each internal transfer lasts a fixed number of cycles, two by default. During that time `busy` is high so that the host handshake logic can stall. Every host strobe that arrives while `busy` is high is discarded.

The sequencer has three states:
- ST_IDLE waits for a trigger. A byte-0 write or a byte-0 read moves it to ST_RUN.
- ST_RUN holds the bus request. It stays there until all but one of the access cycles have passed, then moves to ST_LAST.
- ST_LAST is the final request cycle. In this cycle read data is captured and the address steps. It always returns to ST_IDLE.

Top module: `ireg_bridge`

## Requirements
- R1: After reset, the address is 0x000, both increment enables are 0, all data bytes are 0, `host_rdata` is 0, and `busy` and `ib_req` are low.
- R2: Writing location 7 loads address bits 11:8 from data bits 3:0, the write-increment enable from bit 7 and the read-increment enable from bit 6. Writing location 6 loads address bits 7:0. The two locations may be written in either order. Reading location 7 returns {wr_inc, rd_inc, 2'b00, addr[11:8]}, and reading location 6 returns addr[7:0]. Locations 4 and 5 read as 0, and writes to them change nothing.
- R3: Locations 3, 2, 1 and 0 hold word bits 31:24, 23:16, 15:8 and 7:0. A write to location 0 stores that byte and starts an internal write. In that write `ib_we`=1, `ib_addr` is the current address and `ib_wdata` is the four bytes.
- R4: A read strobe on location 0 starts an internal read with `ib_we`=0. When the read completes, `ib_rdata` is latched into all four bytes, and `host_rdata` shows bits 7:0 once `busy` falls.
- R5: A read strobe on locations 1 to 7 starts no transfer. `host_rdata` shows the selected value on the cycle after the strobe. Data bytes return whatever was last latched or written.
- R6: Each transfer holds `ib_req` and `busy` high for exactly 2 cycles. `ib_addr`, `ib_we` and `ib_wdata` stay stable throughout.
- R7: With the write-increment enable set, the address steps by one at the end of each internal write. With it clear, a write leaves the address unchanged.
- R8: With the read-increment enable set, the address steps by one at the end of each internal read. With both enables set, it steps after either kind of transfer.
- R9: Incrementing from 0xFFF wraps to 0x000, and locations 7 and 6 read back the wrapped value.
- R10: Every host write or read strobe seen while `busy` is high is ignored. This covers a second byte-0 trigger and changes to the data bytes.
- R11: For a 16-bit location, writing byte 1 and then byte 0 places those bytes in `ib_wdata[15:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wdata | input | 8 | Host write byte |
| host_wr_stb | input | 8 | One-hot write strobe per host location 0..7 |
| host_rd_stb | input | 8 | One-hot read strobe per host location 0..7 |
| host_rdata | output | 8 | Registered host read byte |
| busy | output | 1 | Internal transfer in progress |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus write (1) or read (0) |
| ib_addr | output | 12 | Internal address (always the current address) |
| ib_wdata | output | 32 | Internal write word |
| ib_rdata | input | 32 | Internal read word, sampled in the last request cycle |

## Verification
The bench builds the bridge with its defaults: a 12-bit address, a 32-bit word and two-cycle transfers. The 12-bit address makes the 0xFFF-to-0x000 wrap reachable with just two host writes. The short transfer window makes it cheap to inject strobes in the middle of a transfer and to prove that they are discarded. A bench-side bus responder returns an address-derived word, so every byte latched by a read can be predicted.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } acc_state_t;

    localparam int HOST_LOCS = 8;
    localparam int LOC_UPPER = 7;
    localparam int LOC_LOWER = 6;
    localparam int LOW_ADDR_W = 8;

endpackage

// File: rtl/ireg_fsm.sv
module ireg_fsm
    import ireg_pkg::*;
#(
    parameter int ACC_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_wr,
    input  logic trig_rd,
    output logic busy,
    output logic req,
    output logic acc_we,
    output logic done
);
    localparam int CNT_W = (ACC_CYC > 2) ? $clog2(ACC_CYC) : 1;
    localparam logic [CNT_W-1:0] RUN_END = CNT_W'(ACC_CYC - 2);

    acc_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic start;

    assign start = trig_wr | trig_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            acc_we  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE && start)
                acc_we <= trig_wr;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (cnt_q == RUN_END) begin
                    state_d = ST_LAST;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LAST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        req  = busy;
        done = (state_q == ST_LAST);
    end

endmodule

// File: rtl/ireg_addr.sv
module ireg_addr
    import ireg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_upper,
    input  logic              wr_lower,
    input  logic [7:0]        din,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_inc,
    output logic              rd_inc,
    output logic [7:0]        rb_upper,
    output logic [7:0]        rb_lower
);
    localparam int UP_W = ADDR_W - LOW_ADDR_W;

    logic [UP_W-1:0]       upper_q;
    logic [LOW_ADDR_W-1:0] lower_q;
    logic [ADDR_W-1:0]     next_addr;

    assign next_addr = {upper_q, lower_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            wr_inc  <= 1'b0;
            rd_inc  <= 1'b0;
        end else if (inc) begin
            upper_q <= next_addr[ADDR_W-1:LOW_ADDR_W];
            lower_q <= next_addr[LOW_ADDR_W-1:0];
        end else begin
            if (wr_upper) begin
                upper_q <= din[UP_W-1:0];
                wr_inc  <= din[7];
                rd_inc  <= din[6];
            end
            if (wr_lower)
                lower_q <= din;
        end
    end

    assign addr     = {upper_q, lower_q};
    assign rb_upper = 8'({wr_inc, rd_inc} << 6) | 8'(upper_q);
    assign rb_lower = lower_q;

endmodule

// File: rtl/ireg_bytes.sv
module ireg_bytes #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W/8-1:0] wr_stb,
    input  logic [7:0]        din,
    input  logic              load_all,
    input  logic [DATA_W-1:0] load_word,
    output logic [DATA_W-1:0] word
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '0;
            else if (load_all)
                byte_q <= load_word[8*i +: 8];
            else if (wr_stb[i])
                byte_q <= din;
        end
        assign word[8*i +: 8] = byte_q;
    end

endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
    import ireg_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int ACC_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        host_wdata,
    input  logic [7:0]        host_wr_stb,
    input  logic [7:0]        host_rd_stb,
    output logic [7:0]        host_rdata,
    output logic              busy,
    output logic              ib_req,
    output logic              ib_we,
    output logic [ADDR_W-1:0] ib_addr,
    output logic [DATA_W-1:0] ib_wdata,
    input  logic [DATA_W-1:0] ib_rdata
);
    localparam int NBYTES = DATA_W / 8;

    logic [HOST_LOCS-1:0] wr_ok, rd_ok;
    logic trig_wr, trig_rd, done, acc_we, inc;
    logic wr_inc, rd_inc;
    logic [7:0] rb_upper, rb_lower;
    logic [DATA_W-1:0] word;
    logic [7:0] rd_val;
    logic rd_hit;

    assign wr_ok   = host_wr_stb & {HOST_LOCS{~busy}};
    assign rd_ok   = host_rd_stb & {HOST_LOCS{~busy}};
    assign trig_wr = wr_ok[0];
    assign trig_rd = rd_ok[0] & ~wr_ok[0];

    ireg_fsm #(.ACC_CYC(ACC_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .trig_wr(trig_wr), .trig_rd(trig_rd),
        .busy(busy), .req(ib_req), .acc_we(acc_we), .done(done)
    );

    assign inc = done & (acc_we ? wr_inc : rd_inc);

    ireg_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .wr_upper(wr_ok[LOC_UPPER]), .wr_lower(wr_ok[LOC_LOWER]),
        .din(host_wdata), .inc(inc),
        .addr(ib_addr), .wr_inc(wr_inc), .rd_inc(rd_inc),
        .rb_upper(rb_upper), .rb_lower(rb_lower)
    );

    ireg_bytes #(.DATA_W(DATA_W)) u_bytes (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_ok[NBYTES-1:0]), .din(host_wdata),
        .load_all(done & ~acc_we), .load_word(ib_rdata),
        .word(word)
    );

    assign ib_we    = acc_we;
    assign ib_wdata = word;

    // host read mux for locations other than 0
    always_comb begin
        rd_val = '0;
        rd_hit = 1'b0;
        for (int k = 1; k < HOST_LOCS; k++) begin
            if (rd_ok[k]) begin
                rd_hit = 1'b1;
                if (k < NBYTES)
                    rd_val = 8'(word >> (8 * k));
                else if (k == LOC_UPPER)
                    rd_val = rb_upper;
                else if (k == LOC_LOWER)
                    rd_val = rb_lower;
                else
                    rd_val = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (done && !acc_we)
            host_rdata <= ib_rdata[7:0];
        else if (rd_hit)
            host_rdata <= rd_val;
    end

endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int ACC_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ib_req,
    input logic              ib_we,
    input logic [ADDR_W-1:0] ib_addr,
    input logic [DATA_W-1:0] ib_wdata,
    input logic              wr0,
    input logic              rd0,
    input logic              wr_inc,
    input logic              rd_inc
);
    localparam int RL_W = $clog2(ACC_CYC + 1) + 1;
    logic [RL_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_len <= '0;
        else if (ib_req) run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end

    // R6
    req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> run_len < RL_W'(ACC_CYC));
    // R6
    req_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ib_req && run_len != 0) |-> run_len == RL_W'(ACC_CYC));
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && run_len != 0) |-> ($stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)));
    // R3
    wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && !busy) |=> (ib_req && ib_we));
    // R4
    rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !wr0 && !busy) |=> (ib_req && !ib_we));
    // R10
    busy_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && run_len == 0) |-> $past(!busy));
    // R7
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ib_req && run_len == RL_W'(ACC_CYC) && $past(ib_we) && wr_inc)
        |-> ib_addr == ADDR_W'($past(ib_addr) + 1'b1));
    // R8
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ib_req && run_len == RL_W'(ACC_CYC) && !$past(ib_we) && rd_inc)
        |-> ib_addr == ADDR_W'($past(ib_addr) + 1'b1));
    // R7
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ib_req && run_len == RL_W'(ACC_CYC) && ($past(ib_we) ? !wr_inc : !rd_inc))
        |-> ib_addr == $past(ib_addr));

endmodule

bind ireg_bridge ireg_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ib_req(ib_req), .ib_we(ib_we),
    .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .wr0(host_wr_stb[0]), .rd0(host_rd_stb[0]),
    .wr_inc(wr_inc), .rd_inc(rd_inc)
);

// File: tb/sim_ireg_bridge.sv
module sim_ireg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_wr_stb = '0;
    logic [7:0]  host_rd_stb = '0;
    logic [7:0]  host_rdata;
    logic        busy, ib_req, ib_we;
    logic [11:0] ib_addr;
    logic [31:0] ib_wdata, ib_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        bit          we;
        logic [11:0] addr;
        logic [31:0] wdata;
        string       tag;
    } txn_t;
    txn_t expq[$];

    always #2 clk = ~clk;

    function automatic logic [31:0] model(logic [11:0] a);
        return {4'hA, a, 4'h5, ~a};
    endfunction

    assign ib_rdata = model(ib_addr);

    ireg_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .host_wdata(host_wdata), .host_wr_stb(host_wr_stb), .host_rd_stb(host_rd_stb),
        .host_rdata(host_rdata), .busy(busy),
        .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr),
        .ib_wdata(ib_wdata), .ib_rdata(ib_rdata)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each bus transfer with the queue, and its length
    bit req_prev = 0;
    int run = 0;
    always @(negedge clk) begin
        if (rst_n && ib_req && !req_prev) begin
            if (expq.size() == 0) begin
                check(0, "R10 unexpected transfer", {19'b0, ib_we, ib_addr}, 32'h0);
            end else begin
                txn_t t;
                t = expq.pop_front();
                check(ib_we == t.we, {t.tag, " we"}, 32'(ib_we), 32'(t.we));
                check(ib_addr == t.addr, {t.tag, " addr"}, 32'(ib_addr), 32'(t.addr));
                if (t.we)
                    check(ib_wdata == t.wdata, {t.tag, " wdata"}, ib_wdata, t.wdata);
            end
        end
        if (rst_n && req_prev && !ib_req)
            check(run == 2, "R6 request length", run, 2);
        run = ib_req ? run + 1 : 0;
        req_prev = ib_req;
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic hwr(int k, logic [7:0] v);
        @(negedge clk);
        host_wdata  = v;
        host_wr_stb = 8'(1 << k);
        @(negedge clk);
        host_wr_stb = '0;
        wait_idle();
    endtask

    task automatic hrd(int k, logic [7:0] exp, string tag);
        @(negedge clk);
        host_rd_stb = 8'(1 << k);
        @(negedge clk);
        host_rd_stb = '0;
        wait_idle();
        check(host_rdata == exp, tag, host_rdata, exp);
    endtask

    task automatic push(bit we, logic [11:0] a, logic [31:0] d, string tag);
        txn_t t;
        t.we = we; t.addr = a; t.wdata = d; t.tag = tag;
        expq.push_back(t);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(host_rdata == 0, "R1 rdata", host_rdata, 0);
        check(!busy && !ib_req, "R1 idle", {busy, ib_req}, 0);
        hrd(7, 8'h00, "R1 upper");
        hrd(6, 8'h00, "R1 lower");
        // R5 stale byte read before any byte-0 read, no transfer
        hrd(2, 8'h00, "R5 stale byte");

        // R2 address setup and readback
        hwr(7, 8'h03);
        hwr(6, 8'h45);
        hrd(7, 8'h03, "R2 upper rb");
        hrd(6, 8'h45, "R2 lower rb");
        hwr(5, 8'hFF);
        hwr(4, 8'hFF);
        hrd(5, 8'h00, "R2 loc5");
        hrd(4, 8'h00, "R2 loc4");

        // R3 full write, R7 no step without enable
        hwr(3, 8'hDE); hwr(2, 8'hAD); hwr(1, 8'hBE);
        push(1, 12'h345, 32'hDEADBEEF, "R3 write");
        hwr(0, 8'hEF);
        hrd(6, 8'h45, "R7 no step");

        // R4 read trigger, R5 other bytes any order
        w = model(12'h345);
        push(0, 12'h345, 0, "R4 read");
        hrd(0, w[7:0], "R4 byte0");
        hrd(3, w[31:24], "R5 byte3");
        hrd(1, w[15:8], "R5 byte1");
        hrd(2, w[23:16], "R5 byte2");
        hrd(6, 8'h45, "R8 no read step");

        // R11 16-bit write with write increment, R7
        hwr(6, 8'h10);
        hwr(7, 8'h80);
        hwr(1, 8'h12);
        push(1, 12'h010, {w[31:16], 16'h1234}, "R11 half write");
        hwr(0, 8'h34);
        hrd(6, 8'h11, "R7 step");
        push(1, 12'h011, {w[31:16], 16'h1299}, "R7 second write");
        hwr(0, 8'h99);
        hrd(6, 8'h12, "R7 step2");
        push(0, 12'h012, 0, "R7 read no step");
        hrd(0, model(12'h012) >> 0, "R4 byte0 b");
        hrd(6, 8'h12, "R7 read no step rb");

        // R9 wrap with read increment, R8
        hwr(7, 8'h4F);
        hwr(6, 8'hFF);
        w = model(12'hFFF);
        push(0, 12'hFFF, 0, "R9 read");
        hrd(0, w[7:0], "R9 byte0");
        hrd(7, 8'h40, "R9 upper wrap");
        hrd(6, 8'h00, "R9 lower wrap");

        // R8 both enables
        hwr(7, 8'hC2);
        hwr(6, 8'h20);
        push(1, 12'h220, {w[31:8], 8'h77}, "R8 both write");
        hwr(0, 8'h77);
        w = model(12'h221);
        push(0, 12'h221, 0, "R8 both read");
        hrd(0, w[7:0], "R8 read");
        hrd(6, 8'h22, "R8 both step");

        // R10 strobes during busy are ignored
        hwr(1, 8'h55);
        push(1, 12'h222, {w[31:16], 16'h5566}, "R10 write");
        @(negedge clk);
        host_wdata = 8'h66; host_wr_stb = 8'h01;
        @(negedge clk);
        host_wdata = 8'hAA; host_wr_stb = 8'h03;
        host_rd_stb = 8'h00;
        @(negedge clk);
        host_wr_stb = 8'h00; host_rd_stb = 8'h01;
        @(negedge clk);
        host_rd_stb = 8'h00;
        wait_idle();
        repeat (3) @(negedge clk);
        check(!busy, "R10 no restart", busy, 0);
        hrd(1, 8'h55, "R10 byte1 kept");
        hrd(6, 8'h23, "R10 one step");

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R3 all transfers seen", expq.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule